// File: doc/BRIEF.md
# Strobe-Based Parallel Host Bus Master

This block is the host-side controller for an 8-bit asynchronous parallel port whose slave uses two active-low select lines (a chip select and a data strobe) and a read/write direction line. An access takes effect only while both select lines are low. On the master side, a valid/ready request interface supplies the address, the direction and the write data. The controller then runs the bus through four timed phases. Setup places address and direction on the bus while the strobes are still high. Strobe pulls both select lines low. Hold raises the strobes but keeps address, direction and write data unchanged. Recovery releases the data bus and keeps the strobes high. A one-cycle done pulse ends the access. For reads, the captured data is returned with that pulse.

The minimum pulse width and inter-access gap depend on the slave's own clock period, and that period shortens once the slave has booted. Each phase length is therefore a count of master clock cycles, given as a parameter. There are two sets of counts: one for before boot and one for after. Each count is the nanosecond minimum divided by the master clock period, rounded up. A boot-state input chooses the set when a request is accepted. The data bus is carried as separate output, output-enable and input vectors, so the pad ring can build the tri-state buffer.

Top module: `hbus_master`

## Requirements
- R1: During and right after reset, `bus_cs_n` and `bus_ds_n` are 1, `bus_data_oe` is 0, `req_ready` is 1 and `rsp_done` is 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both 1. `req_ready` is 1 only in the idle state. A `req_valid` that is held while an access is running starts no further access.
- R3: `bus_addr` and `bus_rnw` (1 = read, 0 = write) take the request's values at least SETUP cycles before the strobes fall. They stay unchanged from that point until the end of the HOLD cycles that follow the strobe rise.
- R4: `bus_cs_n` and `bus_ds_n` fall in the same cycle and rise in the same cycle, and stay low for exactly PULSE cycles.
- R5: For a write, `bus_data_oe` is 1 and `bus_data_out` equals the write data for the whole time the strobes are low, and the value stays the same across the strobe rise.
- R6: For a read, `bus_data_oe` stays 0 for the whole access, including its recovery. `rsp_rdata` is the value of `bus_data_in` sampled at the clock edge that ends the last strobe-low cycle.
- R7: After the HOLD cycles, the strobes stay high for RECOV more cycles. `rsp_done` is then 1 for exactly one cycle, the first idle cycle, which is HOLD+RECOV+1 cycles after the strobe rise.
- R8: If `boot_done` is 0 when a request is accepted, the access uses the pre-boot counts; if it is 1, it uses the post-boot counts. A change of `boot_done` during an access does not change that access's timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_done | input | 1 | 1 once the slave runs at its post-boot clock rate |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (8) | Access address |
| req_wdata | input | DW (8) | Write data |
| rsp_done | output | 1 | One-cycle pulse at the end of recovery |
| rsp_rdata | output | DW (8) | Last captured read data |
| bus_addr | output | AW (8) | Address lines to the slave |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_rnw | output | 1 | Direction line, 1 = read |
| bus_data_out | output | DW (8) | Data driven toward the slave |
| bus_data_oe | output | 1 | Enable for the data drivers |
| bus_data_in | input | DW (8) | Data returned from the slave |

## Verification
The hardest case to reach is a change of `boot_done` while an access is in flight. From outside, the only evidence that the latched count set was used is the strobe width and the gap before the done pulse. The stimulus starts a pre-boot write and raises `boot_done` right after acceptance. It then checks that this access still shows the long pre-boot widths and that the next access shows the short ones. A second hard case is a request held valid while the controller is busy. Here the stimulus keeps `req_valid` high with a different address during a long pre-boot strobe. The monitor reports any strobe that has no matching expected item in the queue.

// File: rtl/hbus_pkg.sv
// Shared types for the strobe bus master.
// Assumes every phase count fits in CNT_W bits and is at least 1.
package hbus_pkg;

    localparam int CNT_W = 8;

    typedef logic [CNT_W-1:0] cnt_t;

    // Cycle counts for one timing regime (pre-boot or post-boot).
    typedef struct packed {
        cnt_t setup;
        cnt_t pulse;
        cnt_t hold;
        cnt_t recov;
    } phase_set_t;

    // One-hot phase encoding: each strobe/drive output is a single flop bit.
    typedef enum logic [4:0] {
        PH_IDLE   = 5'b00001,
        PH_SETUP  = 5'b00010,
        PH_STROBE = 5'b00100,
        PH_HOLD   = 5'b01000,
        PH_RECOV  = 5'b10000
    } phase_e;

    localparam int STROBE_BIT = 2;

endpackage

// File: rtl/hbus_timing_sel.sv
// Chooses the phase-count set from the boot state.
// live_set follows boot_done at once and is used to load the first phase.
// acc_set is latched on capture and holds the counts for the rest of the access.
// Assumes all parameter values are in the range 1 .. 2**CNT_W-1.
module hbus_timing_sel
    import hbus_pkg::*;
#(
    parameter int PRE_SETUP  = 1,
    parameter int PRE_PULSE  = 11,
    parameter int PRE_HOLD   = 1,
    parameter int PRE_RECOV  = 21,
    parameter int POST_SETUP = 1,
    parameter int POST_PULSE = 3,
    parameter int POST_HOLD  = 1,
    parameter int POST_RECOV = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       boot_done,
    input  logic       capture,
    output phase_set_t live_set,
    output phase_set_t acc_set
);

    localparam phase_set_t PRE_SET = '{
        setup: cnt_t'(PRE_SETUP),  pulse: cnt_t'(PRE_PULSE),
        hold:  cnt_t'(PRE_HOLD),   recov: cnt_t'(PRE_RECOV)
    };
    localparam phase_set_t POST_SET = '{
        setup: cnt_t'(POST_SETUP), pulse: cnt_t'(POST_PULSE),
        hold:  cnt_t'(POST_HOLD),  recov: cnt_t'(POST_RECOV)
    };

    // Select the regime that applies right now.
    always_comb live_set = boot_done ? POST_SET : PRE_SET;

    // Freeze the regime for the access being started.
    always_ff @(posedge clk) begin
        if (!rst_n)       acc_set <= PRE_SET;
        else if (capture) acc_set <= live_set;
    end

endmodule

// File: rtl/hbus_phase_timer.sv
// Down-counter for the length of one phase.
// A load of N makes expired rise N-1 cycles later, so the phase lasts N cycles.
// Assumes load_len >= 1.
module hbus_phase_timer
    import hbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  cnt_t load_len,
    output logic expired
);

    cnt_t cnt;

    // Reload on a phase start, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_len - cnt_t'(1);
        else if (cnt != '0)  cnt <= cnt - cnt_t'(1);
    end

    // Flag the final cycle of the current phase.
    always_comb expired = (cnt == '0);

endmodule

// File: rtl/hbus_datapath.sv
// Address, direction and data registers, plus read capture.
// Every bus-facing output is a flop, so no decode glitch reaches the slave.
// Assumes accept, hold_end and capture come from the sequencer and are never high together.
module hbus_datapath #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          hold_end,
    input  logic          capture,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] bus_data_in,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rnw,
    output logic [DW-1:0] bus_data_out,
    output logic          bus_data_oe,
    output logic [DW-1:0] rsp_rdata
);

    // Latch address, direction and write data when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_addr     <= '0;
            bus_rnw      <= 1'b1;
            bus_data_out <= '0;
        end else if (accept) begin
            bus_addr     <= req_addr;
            bus_rnw      <= ~req_write;
            bus_data_out <= req_wdata;
        end
    end

    // Drive the data bus from setup through hold of a write only.
    always_ff @(posedge clk) begin
        if (!rst_n)        bus_data_oe <= 1'b0;
        else if (accept)   bus_data_oe <= req_write;
        else if (hold_end) bus_data_oe <= 1'b0;
    end

    // Sample returned data at the edge that ends the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       rsp_rdata <= '0;
        else if (capture) rsp_rdata <= bus_data_in;
    end

    // R6: the drivers are never enabled while the direction line says read.
    a_r6_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_oe |-> !bus_rnw);

    // R5: write data does not move while it is being driven.
    a_r5_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_data_oe && $past(bus_data_oe)) |-> $stable(bus_data_out));

endmodule

// File: rtl/hbus_master.sv
// Host-side master for an 8-bit strobe-qualified asynchronous parallel port.
// Sequence per access: SETUP -> STROBE (both selects low) -> HOLD -> RECOV -> IDLE.
// The counts are latched per access from the pre- or post-boot set.
// Assumes the slave returns data within PULSE-1 cycles of the strobe fall.
module hbus_master
    import hbus_pkg::*;
#(
    parameter int AW         = 8,
    parameter int DW         = 8,
    parameter int PRE_SETUP  = 1,
    parameter int PRE_PULSE  = 11,
    parameter int PRE_HOLD   = 1,
    parameter int PRE_RECOV  = 21,
    parameter int POST_SETUP = 1,
    parameter int POST_PULSE = 3,
    parameter int POST_HOLD  = 1,
    parameter int POST_RECOV = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boot_done,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_cs_n,
    output logic          bus_ds_n,
    output logic          bus_rnw,
    output logic [DW-1:0] bus_data_out,
    output logic          bus_data_oe,
    input  logic [DW-1:0] bus_data_in
);

    phase_e     phase, phase_nxt;
    phase_set_t live_set, acc_set;
    logic       accept, capture, hold_end, expired, load;
    cnt_t       load_len;

    assign accept   = (phase == PH_IDLE) && req_valid;
    assign capture  = (phase == PH_STROBE) && expired;
    assign hold_end = (phase == PH_HOLD) && expired;

    hbus_timing_sel #(
        .PRE_SETUP (PRE_SETUP),  .PRE_PULSE (PRE_PULSE),
        .PRE_HOLD  (PRE_HOLD),   .PRE_RECOV (PRE_RECOV),
        .POST_SETUP(POST_SETUP), .POST_PULSE(POST_PULSE),
        .POST_HOLD (POST_HOLD),  .POST_RECOV(POST_RECOV)
    ) u_tsel (
        .clk      (clk),
        .rst_n    (rst_n),
        .boot_done(boot_done),
        .capture  (accept),
        .live_set (live_set),
        .acc_set  (acc_set)
    );

    hbus_phase_timer u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_len(load_len),
        .expired (expired)
    );

    hbus_datapath #(.AW(AW), .DW(DW)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .hold_end    (hold_end),
        .capture     (capture),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .bus_data_in (bus_data_in),
        .bus_addr    (bus_addr),
        .bus_rnw     (bus_rnw),
        .bus_data_out(bus_data_out),
        .bus_data_oe (bus_data_oe),
        .rsp_rdata   (rsp_rdata)
    );

    // Choose the next phase and the length to load into the timer.
    always_comb begin
        phase_nxt = phase;
        load      = 1'b0;
        load_len  = acc_set.setup;
        unique case (phase)
            PH_IDLE: if (req_valid) begin
                phase_nxt = PH_SETUP;  load = 1'b1; load_len = live_set.setup;
            end
            PH_SETUP: if (expired) begin
                phase_nxt = PH_STROBE; load = 1'b1; load_len = acc_set.pulse;
            end
            PH_STROBE: if (expired) begin
                phase_nxt = PH_HOLD;   load = 1'b1; load_len = acc_set.hold;
            end
            PH_HOLD: if (expired) begin
                phase_nxt = PH_RECOV;  load = 1'b1; load_len = acc_set.recov;
            end
            PH_RECOV: if (expired) phase_nxt = PH_IDLE;
            default: phase_nxt = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nxt;
    end

    // Done pulse in the first idle cycle after recovery.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_done <= 1'b0;
        else        rsp_done <= (phase == PH_RECOV) && expired;
    end

    // Both selects come straight from one state flop bit, so they move together without glitches.
    assign bus_cs_n  = ~phase[STROBE_BIT];
    assign bus_ds_n  = ~phase[STROBE_BIT];
    assign req_ready = (phase == PH_IDLE);

    // Count strobe-low cycles for the pulse-width check.
    cnt_t lo_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)              lo_cnt <= '0;
        else if (bus_cs_n)       lo_cnt <= '0;
        else if (lo_cnt != '1)   lo_cnt <= lo_cnt + cnt_t'(1);
    end

    // R4: the strobe stays low for exactly the latched pulse count.
    a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs_n) |-> (lo_cnt == acc_set.pulse));

    // R3: address and direction are already settled when the strobes fall.
    a_r3_setup_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_cs_n) |-> ($stable(bus_addr) && $stable(bus_rnw)));

    // R3: address, direction and data are unchanged across the strobe rise.
    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs_n) |-> ($stable(bus_addr) && $stable(bus_rnw) && $stable(bus_data_out)));

    // R2: once a request is taken the controller reports busy.
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R7: done lasts one cycle and arrives with the idle state.
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (req_ready && bus_cs_n && !bus_data_oe));

endmodule

// File: tb/hbus_master_tb.sv
// Scoreboard bench: the driver queues expected accesses, and a negedge monitor compares them with the bus.
module hbus_master_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PRE_S = 2, PRE_P = 11, PRE_H = 1, PRE_R = 21;
    localparam int PST_S = 1, PST_P = 3,  PST_H = 2, PST_R = 5;

    typedef struct {
        bit         wr;
        logic [7:0] addr;
        logic [7:0] data;
        int         pulse;
        int         hold;
        int         recov;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       boot_done = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_write = 1'b0;
    logic [7:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       rsp_done;
    logic [7:0] rsp_rdata;
    logic [7:0] bus_addr;
    logic       bus_cs_n, bus_ds_n, bus_rnw, bus_data_oe;
    logic [7:0] bus_data_out;
    logic [7:0] bus_data_in;

    int n_run = 0, n_fail = 0, n_issued = 0, n_done = 0;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hbus_master #(
        .AW(8), .DW(8),
        .PRE_SETUP(PRE_S),  .PRE_PULSE(PRE_P),  .PRE_HOLD(PRE_H),  .PRE_RECOV(PRE_R),
        .POST_SETUP(PST_S), .POST_PULSE(PST_P), .POST_HOLD(PST_H), .POST_RECOV(PST_R)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .boot_done(boot_done),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_ds_n(bus_ds_n),
        .bus_rnw(bus_rnw), .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
        .bus_data_in(bus_data_in)
    );

    // Slave model: read data becomes valid only after one full strobe-low cycle.
    int age = 0;
    always @(posedge clk) age <= !bus_cs_n ? age + 1 : 0;
    assign bus_data_in = (age >= 1) ? (bus_addr ^ 8'h5A) : 8'hEE;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Driver: wait for ready, present one request, queue its expected shape.
    task automatic issue(bit wr, logic [7:0] a, logic [7:0] d);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        e.wr = wr; e.addr = a; e.data = d;
        e.pulse = boot_done ? PST_P : PRE_P;
        e.hold  = boot_done ? PST_H : PRE_H;
        e.recov = boot_done ? PST_R : PRE_R;
        exp_q.push_back(e);
        n_issued++;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor state.
    logic       prev_cs = 1'b1, prev_done = 1'b0, prev_rnw = 1'b1;
    logic [7:0] prev_addr = '0, prev_dout = '0;
    int         lo_cnt = 0, since_rise = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_cs && !bus_cs_n) begin
                lo_cnt = 0;
                chk(exp_q.size() != 0, "R2", "strobe with no accepted request", 1, 0);
                if (exp_q.size() != 0) begin
                    chk(bus_addr == exp_q[0].addr, "R3", "address at strobe fall", bus_addr, exp_q[0].addr);
                    chk(bus_rnw == !exp_q[0].wr, "R3", "direction at strobe fall", bus_rnw, !exp_q[0].wr);
                end
                chk(bus_addr == prev_addr && bus_rnw == prev_rnw, "R3", "setup stability", bus_addr, prev_addr);
            end
            if (!bus_cs_n) begin
                lo_cnt++;
                chk(bus_ds_n == 1'b0, "R4", "data strobe follows chip select", bus_ds_n, 0);
                if (exp_q.size() != 0 && exp_q[0].wr) begin
                    chk(bus_data_oe == 1'b1, "R5", "write drive enable", bus_data_oe, 1);
                    chk(bus_data_out == exp_q[0].data, "R5", "write data", bus_data_out, exp_q[0].data);
                end
            end
            if (!prev_cs && bus_cs_n) begin
                if (exp_q.size() != 0)
                    chk(lo_cnt == exp_q[0].pulse, "R4", "strobe-low cycles", lo_cnt, exp_q[0].pulse);
                chk(bus_addr == prev_addr && bus_rnw == prev_rnw && bus_data_out == prev_dout,
                    "R3", "hold stability at rise", bus_addr, prev_addr);
                since_rise = 0;
            end
            if (bus_cs_n) since_rise++;
            if (exp_q.size() != 0 && !exp_q[0].wr)
                chk(bus_data_oe == 1'b0, "R6", "no drive during read", bus_data_oe, 0);
            if (rsp_done) begin
                chk(!prev_done, "R7", "done pulse single cycle", prev_done, 0);
                chk(exp_q.size() != 0, "R7", "done with no access", 0, 1);
                if (exp_q.size() != 0) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(since_rise == e.hold + e.recov + 1, "R7", "cycles from rise to done",
                        since_rise, e.hold + e.recov + 1);
                    if (!e.wr)
                        chk(rsp_rdata == (e.addr ^ 8'h5A), "R6", "read data", rsp_rdata, e.addr ^ 8'h5A);
                end
                n_done++;
            end
            prev_cs   = bus_cs_n;
            prev_done = rsp_done;
            prev_addr = bus_addr;
            prev_rnw  = bus_rnw;
            prev_dout = bus_data_out;
        end
    end

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: actual 1 expected 0");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(bus_cs_n && bus_ds_n, "R1", "strobes high in reset", bus_cs_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_cs_n == 1'b1 && bus_ds_n == 1'b1, "R1", "strobes high after reset", bus_cs_n, 1);
        chk(bus_data_oe == 1'b0, "R1", "drivers off after reset", bus_data_oe, 0);
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(rsp_done == 1'b0, "R1", "no done after reset", rsp_done, 0);

        // Pre-boot accesses, back to back, mixed directions.
        issue(1'b1, 8'h10, 8'hA5);
        issue(1'b0, 8'h22, 8'h00);
        issue(1'b1, 8'h33, 8'h3C);
        issue(1'b0, 8'h33, 8'h00);

        // R2: a request held valid while busy is not taken.
        issue(1'b0, 8'h44, 8'h00);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'hFF; req_wdata = 8'h99;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(req_ready == 1'b0, "R2", "ready low while busy", req_ready, 0);
        end
        req_valid = 1'b0;

        // R8: boot completes mid-access; this access keeps pre-boot counts.
        issue(1'b1, 8'h55, 8'h77);
        boot_done = 1'b1;
        issue(1'b0, 8'h55, 8'h00);
        issue(1'b1, 8'hFF, 8'h00);
        issue(1'b0, 8'h00, 8'h00);
        issue(1'b0, 8'hFF, 8'h00);
        issue(1'b1, 8'h81, 8'hFF);

        for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R7", "all accesses completed", exp_q.size(), 0);
        chk(n_done == n_issued, "R7", "done count", n_done, n_issued);
        chk(bus_data_oe == 1'b0 && bus_cs_n == 1'b1, "R6", "bus released when idle", bus_data_oe, 0);
        summary();
    end

endmodule